// File: doc/BRIEF.md
# Pin Request and EOI Delivery Engine

This block sits between the interrupt input pins of an interrupt router and the fabric that carries interrupt messages to the processors. Each pin reports assertion and deassertion events. The block keeps one request bit and one remote-acknowledge bit per pin, and decides when a pin may be handed to the fabric. It hands over one delivery at a time and waits for the fabric to answer "accepted" or "not delivered". Vector, trigger type and mask come from an external entry store. That store also pulses a per-pin strobe when the low word of an entry is rewritten.

Edge-type pins merge a new assertion into a request that is still outstanding. Level-type pins stay blocked after an accepted delivery until an end-of-interrupt (EOI) with a matching vector arrives. That EOI releases the pin and, if the pin is still requesting and unmasked, issues it again at once. A pin that is redelivered this way too many times in a row is throttled. Its redelivery is postponed by a fixed number of cycles. When that wait ends, every level pin that is requesting and not blocked is issued.

Top module: `pin_irq_engine`

## Requirements
- R1: After reset no pin has a request bit or a remote-acknowledge bit set, and `dlv_valid` is low.
- R2: A deassertion event (`pin_evt_valid` with `pin_evt_level`=0) clears that pin's request bit on the next clock, whatever its trigger type.
- R3: An assertion event raises `coal_pulse` for that pin, in the same cycle, in two cases: the pin is edge-type (`cfg_level_trig`=0) and its request bit is already set, or the pin is level-type and its remote-acknowledge bit is set. Otherwise the assertion sets the request bit and schedules a delivery.
- R4: A pin whose `cfg_mask` bit is 1 is never delivered. Its scheduled delivery is dropped, but its request bit stays set.
- R5: Issuing a delivery for an edge-type pin clears that pin's request bit.
- R6: When the fabric answers an outstanding level-type delivery with `res_accepted`=1, the pin's remote-acknowledge bit is set. A "not delivered" answer (`res_accepted`=0) leaves it clear.
- R7: An EOI (`eoi_valid`) whose vector equals a level-type pin's `cfg_vector` clears that pin's remote-acknowledge bit. It redelivers the pin only if the pin is unmasked and its request bit is still set. An EOI whose vector differs changes nothing.
- R8: Each pin counts back-to-back EOI redeliveries. The STORM_LIMIT-th one is not issued. Instead the defer timer is started and the count returns to zero. A matching EOI that finds the pin masked or not requesting also clears the count.
- R9: DEFER_CYCLES cycles after the timer starts, every level-type pin with its request bit set and its remote-acknowledge bit clear is scheduled, including pins that were not involved in the storm.
- R10: A `cfg_lo_wr` strobe clears that pin's remote-acknowledge bit. If the pin is level-type and requesting, it is scheduled again.
- R11: Only one delivery is outstanding at a time. `dlv_pin`, `dlv_vector` and `dlv_level` hold steady until `res_valid`. Among pins scheduled together the lowest index goes first (round-robin when ARB_MODE selects it).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_evt_valid | input | NPINS | Per-pin event strobe |
| pin_evt_level | input | NPINS | Event level: 1 assertion, 0 deassertion |
| cfg_vector | input | NPINS*VEC_W | Per-pin vector, pin i at bits i*VEC_W upward |
| cfg_level_trig | input | NPINS | 1 level-type, 0 edge-type |
| cfg_mask | input | NPINS | 1 masks the pin |
| cfg_lo_wr | input | NPINS | Entry low-word write strobe |
| eoi_valid | input | 1 | EOI broadcast strobe |
| eoi_vector | input | VEC_W | Vector carried by the EOI |
| dlv_valid | output | 1 | Delivery request outstanding |
| dlv_pin | output | $clog2(NPINS) | Pin being delivered |
| dlv_vector | output | VEC_W | Vector being delivered |
| dlv_level | output | 1 | Delivery is level-type |
| res_valid | input | 1 | Fabric answer strobe |
| res_accepted | input | 1 | 1 accepted, 0 not delivered |
| irr_pend | output | NPINS | Request bits |
| remote_irr | output | NPINS | Remote-acknowledge bits |
| coal_pulse | output | NPINS | Coalesced-assertion indication |

## Verification
Several properties are checked on every cycle: delivery fields stay stable while waiting for an answer, an edge pin's request bit is cleared at issue, a masked pin is never issued, an accepted level delivery sets the remote-acknowledge bit, a deassertion clears the request bit, and a coalescence pulse is raised only against existing state. Other behaviour only the directed scenarios can show. These include the immediate redelivery after an EOI, the exact point where the storm counter defers, and the clearing of that counter by a non-requesting EOI. They also include the timer sweeping up a pin that was unmasked while the timer ran, redelivery on an entry write, and the lowest-index order.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;

   typedef enum logic {
      ARB_LOWEST      = 1'b0,
      ARB_ROUND_ROBIN = 1'b1
   } arb_mode_e;

   localparam int unsigned DEF_NPINS        = 24;
   localparam int unsigned DEF_VEC_W        = 8;
   localparam int unsigned DEF_STORM_LIMIT  = 10000;
   localparam int unsigned DEF_DEFER_CYCLES = 100000;

endpackage

// File: rtl/pin_irq_slice.sv
module pin_irq_slice #(
   parameter int unsigned VEC_W       = 8,
   parameter int unsigned STORM_LIMIT = 10000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             evt_valid,
   input  logic             evt_level,
   input  logic             trig_level,
   input  logic             masked,
   input  logic [VEC_W-1:0] entry_vec,
   input  logic             lo_wr,
   input  logic             eoi_valid,
   input  logic [VEC_W-1:0] eoi_vec,
   input  logic             defer_fire,
   input  logic             issue,
   input  logic             res_set,
   output logic             irr_q,
   output logic             rirr_q,
   output logic             eligible,
   output logic             coal,
   output logic             defer_req
);
   localparam int unsigned CW = $clog2(STORM_LIMIT + 1);

   logic          svc_q;
   logic [CW-1:0] cnt_q;
   logic          rise, fall, eoi_hit, redeliver_ok, storm_hit, svc_set;
   logic          irr_n, rirr_n, svc_n;
   logic [CW-1:0] cnt_n;

   assign rise         = evt_valid & evt_level;
   assign fall         = evt_valid & ~evt_level;
   assign eoi_hit      = eoi_valid & trig_level & (entry_vec == eoi_vec);
   assign coal         = rise & (trig_level ? rirr_q : irr_q);
   assign eligible     = svc_q & ~masked & irr_q & ~(trig_level & rirr_q);
   assign redeliver_ok = eoi_hit & ~masked & irr_q;
   assign storm_hit    = redeliver_ok & (cnt_q == CW'(STORM_LIMIT - 1));
   assign defer_req    = storm_hit;

   assign svc_set = (rise & ~coal)
                  | (lo_wr & trig_level & irr_q)
                  | (redeliver_ok & ~storm_hit)
                  | (defer_fire & trig_level & irr_q & ~rirr_q);

   always_comb begin
      irr_n = irr_q;
      if (fall) irr_n = 1'b0;
      if (rise) irr_n = 1'b1;
      if (issue && !trig_level) irr_n = 1'b0;
   end

   assign rirr_n = (rirr_q & ~(eoi_hit | lo_wr)) | res_set;
   assign svc_n  = (svc_q & eligible & ~issue) | svc_set;

   always_comb begin
      cnt_n = cnt_q;
      if (eoi_hit) begin
         if (!redeliver_ok)  cnt_n = '0;
         else if (storm_hit) cnt_n = '0;
         else                cnt_n = cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irr_q  <= 1'b0;
         rirr_q <= 1'b0;
         svc_q  <= 1'b0;
         cnt_q  <= '0;
      end else begin
         irr_q  <= irr_n;
         rirr_q <= rirr_n;
         svc_q  <= svc_n;
         cnt_q  <= cnt_n;
      end
   end

endmodule

// File: rtl/pin_irq_arbiter.sv
module pin_irq_arbiter #(
   parameter int unsigned N  = 4,
   parameter int unsigned PW = 2
) (
   input  logic [N-1:0]  req,
   input  logic [PW-1:0] base,
   output logic          any,
   output logic [PW-1:0] idx
);
   always_comb begin
      any = 1'b0;
      idx = '0;
      for (int k = N - 1; k >= 0; k--) begin
         int j;
         j = int'(base) + k;
         if (j >= int'(N)) j = j - int'(N);
         if (req[j]) begin
            any = 1'b1;
            idx = PW'(j);
         end
      end
   end

endmodule

// File: rtl/pin_irq_defer_timer.sv
module pin_irq_defer_timer #(
   parameter int unsigned DEFER_CYCLES = 100000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic fire
);
   localparam int unsigned TW = $clog2(DEFER_CYCLES + 1);

   logic          running_q;
   logic [TW-1:0] cnt_q;

   assign fire = running_q & (cnt_q == TW'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         running_q <= 1'b0;
         cnt_q     <= '0;
      end else if (start && (!running_q || fire)) begin
         running_q <= 1'b1;
         cnt_q     <= TW'(DEFER_CYCLES);
      end else if (fire) begin
         running_q <= 1'b0;
         cnt_q     <= '0;
      end else if (running_q) begin
         cnt_q     <= cnt_q - 1'b1;
      end
   end

endmodule

// File: rtl/pin_irq_engine.sv
module pin_irq_engine
   import pin_irq_pkg::*;
#(
   parameter int unsigned NPINS        = DEF_NPINS,
   parameter int unsigned VEC_W        = DEF_VEC_W,
   parameter int unsigned STORM_LIMIT  = DEF_STORM_LIMIT,
   parameter int unsigned DEFER_CYCLES = DEF_DEFER_CYCLES,
   parameter arb_mode_e   ARB_MODE     = ARB_LOWEST,
   localparam int unsigned PW          = $clog2(NPINS)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NPINS-1:0]       pin_evt_valid,
   input  logic [NPINS-1:0]       pin_evt_level,
   input  logic [NPINS*VEC_W-1:0] cfg_vector,
   input  logic [NPINS-1:0]       cfg_level_trig,
   input  logic [NPINS-1:0]       cfg_mask,
   input  logic [NPINS-1:0]       cfg_lo_wr,
   input  logic                   eoi_valid,
   input  logic [VEC_W-1:0]       eoi_vector,
   output logic                   dlv_valid,
   output logic [PW-1:0]          dlv_pin,
   output logic [VEC_W-1:0]       dlv_vector,
   output logic                   dlv_level,
   input  logic                   res_valid,
   input  logic                   res_accepted,
   output logic [NPINS-1:0]       irr_pend,
   output logic [NPINS-1:0]       remote_irr,
   output logic [NPINS-1:0]       coal_pulse
);
   if (NPINS < 2 || NPINS > 64) begin : g_bad_npins
      $error("pin_irq_engine: NPINS must lie in 2..64");
   end
   if (VEC_W < 1) begin : g_bad_vec_w
      $error("pin_irq_engine: VEC_W must be at least 1");
   end
   if (STORM_LIMIT < 2) begin : g_bad_storm
      $error("pin_irq_engine: STORM_LIMIT must be at least 2");
   end
   if (DEFER_CYCLES < 1) begin : g_bad_defer
      $error("pin_irq_engine: DEFER_CYCLES must be at least 1");
   end

   logic [NPINS-1:0] eligible, issue, res_set, defer_req;
   logic             defer_fire, arb_any, grant;
   logic [PW-1:0]    arb_idx, arb_base;
   logic             busy_q, lvl_q;
   logic [PW-1:0]    pin_q;
   logic [VEC_W-1:0] vec_q;

   assign grant = arb_any & ~busy_q;

   for (genvar g = 0; g < NPINS; g++) begin : g_pin
      assign issue[g]   = grant & (arb_idx == PW'(g));
      assign res_set[g] = busy_q & res_valid & res_accepted & lvl_q
                        & (pin_q == PW'(g));

      pin_irq_slice #(
         .VEC_W       (VEC_W),
         .STORM_LIMIT (STORM_LIMIT)
      ) u_slice (
         .clk        (clk),
         .rst_n      (rst_n),
         .evt_valid  (pin_evt_valid[g]),
         .evt_level  (pin_evt_level[g]),
         .trig_level (cfg_level_trig[g]),
         .masked     (cfg_mask[g]),
         .entry_vec  (cfg_vector[g*VEC_W +: VEC_W]),
         .lo_wr      (cfg_lo_wr[g]),
         .eoi_valid  (eoi_valid),
         .eoi_vec    (eoi_vector),
         .defer_fire (defer_fire),
         .issue      (issue[g]),
         .res_set    (res_set[g]),
         .irr_q      (irr_pend[g]),
         .rirr_q     (remote_irr[g]),
         .eligible   (eligible[g]),
         .coal       (coal_pulse[g]),
         .defer_req  (defer_req[g])
      );
   end

   if (ARB_MODE == ARB_ROUND_ROBIN) begin : g_rr
      logic [PW-1:0] ptr_q;
      always_ff @(posedge clk) begin
         if (!rst_n)      ptr_q <= '0;
         else if (grant)  ptr_q <= (arb_idx == PW'(NPINS - 1)) ? '0 : arb_idx + 1'b1;
      end
      assign arb_base = ptr_q;
   end else begin : g_lowest
      assign arb_base = '0;
   end

   pin_irq_arbiter #(
      .N  (NPINS),
      .PW (PW)
   ) u_arb (
      .req  (eligible),
      .base (arb_base),
      .any  (arb_any),
      .idx  (arb_idx)
   );

   pin_irq_defer_timer #(
      .DEFER_CYCLES (DEFER_CYCLES)
   ) u_defer (
      .clk   (clk),
      .rst_n (rst_n),
      .start (|defer_req),
      .fire  (defer_fire)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         pin_q  <= '0;
         vec_q  <= '0;
         lvl_q  <= 1'b0;
      end else if (grant) begin
         busy_q <= 1'b1;
         pin_q  <= arb_idx;
         vec_q  <= cfg_vector[int'(arb_idx)*VEC_W +: VEC_W];
         lvl_q  <= cfg_level_trig[arb_idx];
      end else if (busy_q && res_valid) begin
         busy_q <= 1'b0;
      end
   end

   assign dlv_valid  = busy_q;
   assign dlv_pin    = pin_q;
   assign dlv_vector = vec_q;
   assign dlv_level  = lvl_q;

endmodule

// File: rtl/pin_irq_engine_chk.sv
module pin_irq_engine_chk #(
   parameter int unsigned NPINS = 4,
   parameter int unsigned VEC_W = 8,
   parameter int unsigned PW    = 2
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [NPINS-1:0]       pin_evt_valid,
   input logic [NPINS-1:0]       pin_evt_level,
   input logic [NPINS-1:0]       cfg_mask,
   input logic                   dlv_valid,
   input logic [PW-1:0]          dlv_pin,
   input logic [VEC_W-1:0]       dlv_vector,
   input logic                   dlv_level,
   input logic                   res_valid,
   input logic                   res_accepted,
   input logic [NPINS-1:0]       irr_pend,
   input logic [NPINS-1:0]       remote_irr,
   input logic [NPINS-1:0]       coal_pulse
);
   logic [NPINS-1:0] mask_d;
   always_ff @(posedge clk) begin
      if (!rst_n) mask_d <= '1;
      else        mask_d <= cfg_mask;
   end

   // R11
   dlv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dlv_valid && !res_valid) |=> (dlv_valid && $stable(dlv_pin)
                                     && $stable(dlv_vector) && $stable(dlv_level)));

   // R5
   edge_issue_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(dlv_valid) && !dlv_level) |-> !irr_pend[dlv_pin]);

   // R4
   masked_never_issued_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dlv_valid) |-> !mask_d[dlv_pin]);

   // R6
   accept_sets_rirr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dlv_valid && res_valid && res_accepted && dlv_level)
         |=> remote_irr[$past(dlv_pin)]);

   for (genvar g = 0; g < NPINS; g++) begin : g_pin_chk
      // R2
      deassert_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (pin_evt_valid[g] && !pin_evt_level[g]) |=> !irr_pend[g]);

      // R3
      coal_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
         coal_pulse[g] |-> (irr_pend[g] || remote_irr[g]));
   end

endmodule

bind pin_irq_engine pin_irq_engine_chk #(
   .NPINS (NPINS),
   .VEC_W (VEC_W),
   .PW    (PW)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .pin_evt_valid (pin_evt_valid),
   .pin_evt_level (pin_evt_level),
   .cfg_mask      (cfg_mask),
   .dlv_valid     (dlv_valid),
   .dlv_pin       (dlv_pin),
   .dlv_vector    (dlv_vector),
   .dlv_level     (dlv_level),
   .res_valid     (res_valid),
   .res_accepted  (res_accepted),
   .irr_pend      (irr_pend),
   .remote_irr    (remote_irr),
   .coal_pulse    (coal_pulse)
);

// File: tb/pin_irq_engine_bench.sv
module pin_irq_engine_bench;
   import pin_irq_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int NP    = 4;
   localparam int VW    = 8;
   localparam int STORM = 5;
   localparam int DEFER = 20;
   localparam int PW    = $clog2(NP);

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [NP-1:0]    pin_evt_valid = '0, pin_evt_level = '0;
   logic [NP*VW-1:0] cfg_vector = '0;
   logic [NP-1:0]    cfg_level_trig = '0, cfg_mask = '1, cfg_lo_wr = '0;
   logic             eoi_valid = 1'b0;
   logic [VW-1:0]    eoi_vector = '0;
   logic             dlv_valid, dlv_level;
   logic [PW-1:0]    dlv_pin;
   logic [VW-1:0]    dlv_vector;
   logic             res_valid = 1'b0, res_accepted = 1'b0;
   logic [NP-1:0]    irr_pend, remote_irr, coal_pulse;

   int n_cmp = 0;
   int n_err = 0;
   int cyc   = 0;
   bit done  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pin_irq_engine #(
      .NPINS (NP), .VEC_W (VW), .STORM_LIMIT (STORM),
      .DEFER_CYCLES (DEFER), .ARB_MODE (ARB_LOWEST)
   ) u_pin_irq_engine (
      .clk (clk), .rst_n (rst_n),
      .pin_evt_valid (pin_evt_valid), .pin_evt_level (pin_evt_level),
      .cfg_vector (cfg_vector), .cfg_level_trig (cfg_level_trig),
      .cfg_mask (cfg_mask), .cfg_lo_wr (cfg_lo_wr),
      .eoi_valid (eoi_valid), .eoi_vector (eoi_vector),
      .dlv_valid (dlv_valid), .dlv_pin (dlv_pin),
      .dlv_vector (dlv_vector), .dlv_level (dlv_level),
      .res_valid (res_valid), .res_accepted (res_accepted),
      .irr_pend (irr_pend), .remote_irr (remote_irr), .coal_pulse (coal_pulse)
   );

   function automatic int vec_of(int p);
      return 'h30 + 16 * p;
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
   endtask

   task automatic do_reset(input logic [NP-1:0] lvl_cfg, input logic [NP-1:0] msk);
      rst_n = 1'b0;
      pin_evt_valid = '0; pin_evt_level = '0; cfg_lo_wr = '0;
      eoi_valid = 1'b0; res_valid = 1'b0;
      for (int p = 0; p < NP; p++) cfg_vector[p*VW +: VW] = VW'(vec_of(p));
      cfg_level_trig = lvl_cfg;
      cfg_mask = msk;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic evt(input int p, input logic lvl, output logic coal);
      @(negedge clk);
      pin_evt_valid[p] = 1'b1;
      pin_evt_level[p] = lvl;
      #1 coal = coal_pulse[p];
      @(negedge clk);
      pin_evt_valid[p] = 1'b0;
   endtask

   task automatic eoi(input int v);
      @(negedge clk);
      eoi_valid = 1'b1;
      eoi_vector = VW'(v);
      @(negedge clk);
      eoi_valid = 1'b0;
   endtask

   task automatic lo_write(input int p);
      @(negedge clk);
      cfg_lo_wr[p] = 1'b1;
      @(negedge clk);
      cfg_lo_wr[p] = 1'b0;
   endtask

   task automatic quiet(input string req, input int n);
      int seen = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (dlv_valid) seen = 1;
      end
      chk(req, seen, 0);
   endtask

   task automatic take(input string req, input int p, input logic lvl,
                       input logic acc, input int maxw);
      int got = 0;
      for (int i = 0; i < maxw; i++) begin
         @(negedge clk);
         if (dlv_valid) begin got = 1; break; end
      end
      chk(req, got, 1);
      if (got == 1) begin
         chk(req, int'(dlv_pin), p);
         chk(req, int'(dlv_vector), vec_of(p));
         chk(req, int'(dlv_level), int'(lvl));
         res_valid = 1'b1;
         res_accepted = acc;
         @(negedge clk);
         res_valid = 1'b0;
      end
   endtask

   task automatic t_reset();
      do_reset('0, '1);
      // R1
      chk("R1", int'(irr_pend), 0);
      chk("R1", int'(remote_irr), 0);
      chk("R1", int'(dlv_valid), 0);
   endtask

   task automatic t_edge();
      logic c;
      do_reset(4'b0000, 4'b1101);
      evt(1, 1'b1, c);
      chk("R3", int'(c), 0);
      take("R5", 1, 1'b0, 1'b1, 6);
      chk("R5", int'(irr_pend[1]), 0);
      evt(0, 1'b1, c);
      quiet("R4", 6);
      chk("R4", int'(irr_pend[0]), 1);
      evt(0, 1'b1, c);
      chk("R3", int'(c), 1);
      evt(0, 1'b0, c);
      @(negedge clk);
      chk("R2", int'(irr_pend[0]), 0);
   endtask

   task automatic t_level();
      logic c;
      do_reset(4'b0100, 4'b1011);
      evt(2, 1'b1, c);
      take("R6", 2, 1'b1, 1'b1, 6);
      chk("R6", int'(remote_irr[2]), 1);
      evt(2, 1'b1, c);
      chk("R3", int'(c), 1);
      eoi(vec_of(1));
      quiet("R7", 4);
      chk("R7", int'(remote_irr[2]), 1);
      eoi(vec_of(2));
      take("R7", 2, 1'b1, 1'b0, 6);
      chk("R6", int'(remote_irr[2]), 0);
      evt(2, 1'b0, c);
      eoi(vec_of(2));
      quiet("R7", 5);
   endtask

   task automatic t_write();
      logic c;
      do_reset(4'b0010, 4'b1111);
      evt(1, 1'b1, c);
      quiet("R4", 5);
      chk("R4", int'(irr_pend[1]), 1);
      @(negedge clk);
      cfg_mask[1] = 1'b0;
      quiet("R4", 4);
      lo_write(1);
      take("R10", 1, 1'b1, 1'b1, 6);
      chk("R10", int'(remote_irr[1]), 1);
      lo_write(1);
      chk("R10", int'(remote_irr[1]), 0);
      take("R10", 1, 1'b1, 1'b1, 6);
   endtask

   task automatic t_arb();
      do_reset(4'b0000, 4'b0000);
      @(negedge clk);
      pin_evt_valid = 4'b1010; pin_evt_level = 4'b1010;
      @(negedge clk);
      pin_evt_valid = '0;
      take("R11", 1, 1'b0, 1'b1, 6);
      take("R11", 3, 1'b0, 1'b1, 6);
   endtask

   task automatic t_storm();
      logic c;
      do_reset(4'b1100, 4'b0111);
      evt(3, 1'b1, c);
      take("R8", 3, 1'b1, 1'b1, 6);
      for (int k = 1; k < STORM; k++) begin
         eoi(vec_of(3));
         take("R8", 3, 1'b1, 1'b1, 6);
      end
      eoi(vec_of(3));
      quiet("R8", DEFER - 3);
      take("R9", 3, 1'b1, 1'b1, 10);
      for (int k = 0; k < 2; k++) begin
         eoi(vec_of(3));
         take("R8", 3, 1'b1, 1'b1, 6);
      end
      evt(3, 1'b0, c);
      eoi(vec_of(3));
      quiet("R8", 5);
      evt(3, 1'b1, c);
      take("R8", 3, 1'b1, 1'b1, 6);
      for (int k = 1; k < STORM; k++) begin
         eoi(vec_of(3));
         take("R8", 3, 1'b1, 1'b1, 6);
      end
      eoi(vec_of(3));
      evt(2, 1'b1, c);
      @(negedge clk);
      cfg_mask[2] = 1'b0;
      quiet("R9", 10);
      take("R9", 2, 1'b1, 1'b1, 30);
      take("R9", 3, 1'b1, 1'b1, 6);
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 50000 && !done) begin
         done = 1'b1;
         n_cmp++;
         n_err++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 50000);
         summary();
      end
   end

   initial begin
      t_reset();
      t_edge();
      t_level();
      t_write();
      t_arb();
      t_storm();
      done = 1'b1;
      summary();
   end

endmodule